// File: doc/BRIEF.md
# Descriptor Queue Accumulator

This engine gathers descriptor pointers for a host processor. It watches either one hardware queue or a group of up to 32 queues. The group is chosen by a 32-bit mask placed relative to a base queue index. The engine pops 32-bit descriptor values from the watched queues and writes them into a list in host memory. The list is split into two halves that are used in turn. When a half is closed, the engine writes the half's framing word and gives a one-cycle interrupt pulse. The pulse carries the channel number, the half index and the entry count.

A single command write configures the engine. Command code 0x81 enables the channel and loads the rest of the configuration. Any other code disables it. Each half is `max_entries` words long and has room for `max_entries - 1` descriptors. The list can be framed in two ways. In count format, word 0 of the half holds the entry count. In zero-terminated format, a zero word follows the last descriptor. A tick counter paces the interrupts: a half that holds entries is closed once the configured number of timer ticks has passed since the previous interrupt or since the enable. The engine never checks whether the host has read a half before it writes that half again.

Top module: `qacc_engine`

## Requirements
- R1: A command with code 0x81 enables the channel. Any other code disables it. From the cycle after a disabling command, no pop, no memory write and no interrupt occur. The next enable starts again at half 0.
- R2: In single-queue mode only queue `cfg_base_q` is popped, and the mask has no effect.
- R3: In multi-queue mode only queue `cfg_base_q + i` with mask bit i set is popped. Mask bit 0 is the base queue. One pop is made per cycle, visiting the set bits in ascending order and wrapping to the lowest set bit. The visit starts at the lowest set bit after an enable.
- R4: A pop that returns a nonzero value stores that exact 32-bit value as the next entry. A pop that returns zero means the queue is empty, and nothing is stored.
- R5: In count format (`cfg_count_fmt`=1), entry k of a half is written at half base + 1 + k. When the half closes, the entry count is written at the half base.
- R6: In zero-terminated format (`cfg_count_fmt`=0), entry k is written at half base + k. When the half closes, a zero word is written at half base + count, and the half base itself is not written.
- R7: A half closes when it holds `cfg_max_entries - 1` entries, even if no timer ticks arrive.
- R8: A half with at least one entry also closes once `cfg_timer_count` ticks have been counted since the last interrupt or enable. The half never closes on ticks alone while it holds no entries.
- R9: Half 0 starts at `cfg_list_base` and half 1 at `cfg_list_base + cfg_max_entries`. The halves alternate on every interrupt.
- R10: `irq` is high for exactly one cycle per closed half, in the same cycle as the closing write. During that cycle `irq_half`, `irq_count` and `irq_chan` give the half, its entry count and the configured channel.
- R11: A half is overwritten on reuse without any check that the host has read it. The third interrupt after an enable reports half 0 again, and its entries replace the earlier ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Command strobe |
| cfg_cmd | input | 8 | Command code (0x81 enables) |
| cfg_chan | input | CW | Channel number reported with interrupts |
| cfg_base_q | input | QW | Base or single queue index |
| cfg_mask | input | 32 | Queue mask relative to the base |
| cfg_multi | input | 1 | 1 = masked multi-queue mode |
| cfg_count_fmt | input | 1 | 1 = count word, 0 = zero-terminated |
| cfg_max_entries | input | EW | Words per list half |
| cfg_timer_count | input | TW | Pacing delay in timer ticks |
| cfg_list_base | input | AW | Word address of half 0 |
| q_rd_en | output | 1 | Pop strobe |
| q_rd_idx | output | QW | Queue being popped |
| q_rd_data | input | DW | Popped value, zero when empty (same cycle) |
| mem_we | output | 1 | List write strobe |
| mem_addr | output | AW | List write word address |
| mem_wdata | output | DW | List write data |
| timer_tick | input | 1 | Pacing timer tick |
| irq | output | 1 | Half-ready pulse |
| irq_chan | output | CW | Channel of the pulse |
| irq_half | output | 1 | Half that was closed |
| irq_count | output | EW | Entries in the closed half |

## Verification
The hardest situation to reach is the pacing rule with an empty half. The tick count has already expired, yet no interrupt may come until a descriptor arrives, and then the close must follow at once into the second half. The bench fills and closes a half with ticks, then sends more ticks than the limit with every queue empty and confirms that `irq` stays low. It then pushes one descriptor and checks that a one-entry interrupt arrives for half 1 at the expected offset. The mask rotation is exposed by loading several queues unevenly and checking the order of the entries in memory.

// File: rtl/qacc_pkg.sv
package qacc_pkg;

    localparam int          MASK_BITS  = 32;
    localparam int          SEL_W      = $clog2(MASK_BITS);
    localparam logic [7:0]  CMD_ENABLE = 8'h81;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_SCAN  = 2'd1,
        ST_CLOSE = 2'd2
    } acc_state_e;

    typedef enum logic {
        FMT_ZTERM = 1'b0,
        FMT_COUNT = 1'b1
    } list_fmt_e;

    // Next set mask bit strictly after cur, wrapping; returns cur if none other.
    function automatic logic [SEL_W-1:0] next_set(input logic [MASK_BITS-1:0] m,
                                                  input logic [SEL_W-1:0] cur);
        logic [SEL_W-1:0] r;
        logic             found;
        r     = cur;
        found = 1'b0;
        for (int i = 1; i <= MASK_BITS; i++) begin
            logic [SEL_W-1:0] c;
            c = cur + SEL_W'(i);
            if (!found && m[c]) begin
                r     = c;
                found = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/qacc_qsel.sv
module qacc_qsel
    import qacc_pkg::*;
#(
    parameter int QW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [MASK_BITS-1:0] load_mask,
    input  logic                 multi,
    input  logic [MASK_BITS-1:0] mask,
    input  logic [QW-1:0]        base_q,
    input  logic                 advance,
    output logic                 sel_ok,
    output logic [QW-1:0]        q_idx
);

    logic [SEL_W-1:0] sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= '0;
        end else if (load) begin
            sel <= next_set(load_mask, SEL_W'(MASK_BITS - 1));
        end else if (advance && multi) begin
            sel <= next_set(mask, sel);
        end
    end

    assign sel_ok = multi ? (mask != '0) : 1'b1;
    assign q_idx  = multi ? (base_q + QW'(sel)) : base_q;

    // R3
    sel_in_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && multi && !load) |-> mask[sel]);

endmodule

// File: rtl/qacc_pacer.sv
module qacc_pacer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          tick,
    input  logic [TW-1:0] limit,
    output logic          expired
);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (tick && (cnt != '1)) begin
            cnt <= cnt + TW'(1);
        end
    end

    assign expired = (cnt >= limit);

    // R8
    expired_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (expired && !restart) |=> expired);

endmodule

// File: rtl/qacc_listaddr.sv
module qacc_listaddr #(
    parameter int AW = 16,
    parameter int EW = 8
) (
    input  logic [AW-1:0] list_base,
    input  logic [EW-1:0] max_e,
    input  logic          half,
    input  logic [EW-1:0] count,
    input  logic          count_fmt,
    input  logic          closing,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] half_base;
    logic [EW:0]   off;

    always_comb begin
        half_base = list_base + (half ? AW'(max_e) : '0);
        if (closing) begin
            off = count_fmt ? '0 : {1'b0, count};
        end else begin
            off = {1'b0, count} + (count_fmt ? (EW+1)'(1) : '0);
        end
        addr = half_base + AW'(off);
    end

endmodule

// File: rtl/qacc_engine.sv
module qacc_engine
    import qacc_pkg::*;
#(
    parameter int QW = 16,
    parameter int AW = 16,
    parameter int EW = 8,
    parameter int TW = 16,
    parameter int DW = 32,
    parameter int CW = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_valid,
    input  logic [7:0]           cfg_cmd,
    input  logic [CW-1:0]        cfg_chan,
    input  logic [QW-1:0]        cfg_base_q,
    input  logic [MASK_BITS-1:0] cfg_mask,
    input  logic                 cfg_multi,
    input  logic                 cfg_count_fmt,
    input  logic [EW-1:0]        cfg_max_entries,
    input  logic [TW-1:0]        cfg_timer_count,
    input  logic [AW-1:0]        cfg_list_base,
    output logic                 q_rd_en,
    output logic [QW-1:0]        q_rd_idx,
    input  logic [DW-1:0]        q_rd_data,
    output logic                 mem_we,
    output logic [AW-1:0]        mem_addr,
    output logic [DW-1:0]        mem_wdata,
    input  logic                 timer_tick,
    output logic                 irq,
    output logic [CW-1:0]        irq_chan,
    output logic                 irq_half,
    output logic [EW-1:0]        irq_count
);

    typedef struct packed {
        logic [CW-1:0]        chan;
        logic [QW-1:0]        base_q;
        logic [MASK_BITS-1:0] mask;
        logic                 multi;
        list_fmt_e            fmt;
        logic [EW-1:0]        max_e;
        logic [TW-1:0]        tcount;
        logic [AW-1:0]        list_base;
    } acc_cfg_t;

    acc_cfg_t   cfg_q;
    acc_state_e state;
    logic       half;
    logic [EW-1:0] count;

    logic [EW-1:0] cap;
    logic          expired;
    logic          sel_ok;
    logic          close_now;
    logic          pop_now;
    logic          hit;
    logic          closing;
    logic          is_enable;

    assign is_enable = (cfg_cmd == CMD_ENABLE);
    assign cap       = (cfg_q.max_e == '0) ? '0 : (cfg_q.max_e - EW'(1));
    assign closing   = (state == ST_CLOSE);
    assign close_now = (state == ST_SCAN) && (count != '0) &&
                       ((count == cap) || expired);
    assign pop_now   = (state == ST_SCAN) && !close_now && sel_ok && (count < cap);
    assign hit       = pop_now && (q_rd_data != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_OFF;
            half  <= 1'b0;
            count <= '0;
            cfg_q <= '0;
        end else if (cfg_valid) begin
            half  <= 1'b0;
            count <= '0;
            if (is_enable) begin
                state           <= ST_SCAN;
                cfg_q.chan      <= cfg_chan;
                cfg_q.base_q    <= cfg_base_q;
                cfg_q.mask      <= cfg_mask;
                cfg_q.multi     <= cfg_multi;
                cfg_q.fmt       <= cfg_count_fmt ? FMT_COUNT : FMT_ZTERM;
                cfg_q.max_e     <= cfg_max_entries;
                cfg_q.tcount    <= cfg_timer_count;
                cfg_q.list_base <= cfg_list_base;
            end else begin
                state <= ST_OFF;
            end
        end else begin
            unique case (state)
                ST_SCAN: begin
                    if (close_now) begin
                        state <= ST_CLOSE;
                    end else if (hit) begin
                        count <= count + EW'(1);
                    end
                end
                ST_CLOSE: begin
                    state <= ST_SCAN;
                    half  <= ~half;
                    count <= '0;
                end
                default: state <= ST_OFF;
            endcase
        end
    end

    qacc_qsel #(.QW(QW)) u_qsel (
        .clk       (clk),
        .rst       (rst),
        .load      (cfg_valid),
        .load_mask (cfg_mask),
        .multi     (cfg_q.multi),
        .mask      (cfg_q.mask),
        .base_q    (cfg_q.base_q),
        .advance   (pop_now),
        .sel_ok    (sel_ok),
        .q_idx     (q_rd_idx)
    );

    qacc_pacer #(.TW(TW)) u_pacer (
        .clk     (clk),
        .rst     (rst),
        .restart (cfg_valid || closing),
        .tick    (timer_tick && (state != ST_OFF)),
        .limit   (cfg_q.tcount),
        .expired (expired)
    );

    qacc_listaddr #(.AW(AW), .EW(EW)) u_addr (
        .list_base (cfg_q.list_base),
        .max_e     (cfg_q.max_e),
        .half      (half),
        .count     (count),
        .count_fmt (cfg_q.fmt == FMT_COUNT),
        .closing   (closing),
        .addr      (mem_addr)
    );

    assign q_rd_en   = pop_now;
    assign mem_we    = hit || closing;
    assign mem_wdata = closing ? ((cfg_q.fmt == FMT_COUNT) ? DW'(count) : '0)
                               : q_rd_data;
    assign irq       = closing;
    assign irq_half  = half;
    assign irq_count = count;
    assign irq_chan  = cfg_q.chan;

    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R7
    irq_bounds_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((irq_count != '0) && (irq_count <= cap)));

    // R1
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && !is_enable) |=> (!q_rd_en && !mem_we && !irq));

    // R9
    half_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !cfg_valid) |=> (irq_half != $past(irq_half)));

endmodule

// File: tb/qacc_engine_tb.sv
module qacc_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int QW = 16, AW = 16, EW = 8, TW = 16, DW = 32, CW = 5;
    localparam int QBASE = 200;
    localparam logic [AW-1:0] LBASE = 16'h0100;

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_valid = 1'b0, cfg_multi = 1'b0, cfg_count_fmt = 1'b0;
    logic [7:0] cfg_cmd = '0;
    logic [CW-1:0] cfg_chan = '0;
    logic [QW-1:0] cfg_base_q = '0;
    logic [31:0] cfg_mask = '0;
    logic [EW-1:0] cfg_max_entries = '0;
    logic [TW-1:0] cfg_timer_count = '0;
    logic [AW-1:0] cfg_list_base = '0;
    logic q_rd_en, mem_we, irq, irq_half, timer_tick = 1'b0;
    logic [QW-1:0] q_rd_idx;
    logic [DW-1:0] q_rd_data, mem_wdata;
    logic [AW-1:0] mem_addr;
    logic [CW-1:0] irq_chan;
    logic [EW-1:0] irq_count;

    always #(CLK_PERIOD/2) clk = ~clk;

    qacc_engine u_dut (.*);

    int n_cmp = 0, n_err = 0;
    bit done = 0;

    // queue model
    logic [31:0] qm [32][16];
    int head [32];
    int tail [32];
    bit pop_pend = 0;
    int pop_rel = 0;

    always_comb begin
        int rel;
        rel = int'(q_rd_idx) - QBASE;
        q_rd_data = '0;
        if (rel >= 0 && rel < 32)
            if (head[rel] != tail[rel]) q_rd_data = qm[rel][head[rel] % 16];
    end

    always @(posedge clk) if (pop_pend) head[pop_rel] <= head[pop_rel] + 1;

    // monitors
    logic [31:0] mem_m [64];
    int irq_n = 0, bad_pop = 0, bad_wr = 0, pulse_err = 0, wr_n = 0;
    bit prev_irq = 0;
    logic [EW-1:0] log_cnt [16];
    bit log_half [16];
    logic [CW-1:0] log_chan [16];

    always @(negedge clk) begin
        int rel;
        rel = int'(q_rd_idx) - QBASE;
        pop_pend = 0;
        if (!rst) begin
            if (q_rd_en) begin
                if (rel < 0 || rel >= 32) bad_pop++;
                else begin
                    pop_rel = rel;
                    pop_pend = (q_rd_data != 0);
                end
            end
            if (mem_we) begin
                wr_n++;
                if (int'(mem_addr) - int'(LBASE) >= 0 && int'(mem_addr) - int'(LBASE) < 64)
                    mem_m[int'(mem_addr) - int'(LBASE)] = mem_wdata;
                else bad_wr++;
            end
            if (irq) begin
                if (irq_n < 16) begin
                    log_cnt[irq_n] = irq_count; log_half[irq_n] = irq_half; log_chan[irq_n] = irq_chan;
                end
                irq_n++;
                if (prev_irq) pulse_err++;
            end
            prev_irq = irq;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic configure(input logic [7:0] cmd, input logic [CW-1:0] ch, input logic multi,
                             input logic fmt, input logic [31:0] mask, input logic [EW-1:0] maxe,
                             input logic [TW-1:0] tc);
        @(negedge clk);
        cfg_valid = 1; cfg_cmd = cmd; cfg_chan = ch; cfg_multi = multi; cfg_count_fmt = fmt;
        cfg_mask = mask; cfg_max_entries = maxe; cfg_timer_count = tc;
        cfg_base_q = QW'(QBASE); cfg_list_base = LBASE;
        @(negedge clk);
        cfg_valid = 0;
    endtask

    task automatic push(input int q, input logic [31:0] v);
        qm[q][tail[q] % 16] = v;
        tail[q] = tail[q] + 1;
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk); timer_tick = 1;
            @(negedge clk); timer_tick = 0;
        end
    endtask

    task automatic wait_irqs(input int target);
        int k;
        k = 0;
        while (irq_n < target && k < 200) begin @(negedge clk); k++; end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) mem_m[i] = 32'hDEAD_BEEF;
    endtask

    task automatic t_reset();
        check("R1 reset q_rd_en", {31'b0, q_rd_en}, 0);
        check("R1 reset mem_we", {31'b0, mem_we}, 0);
        check("R10 reset irq", {31'b0, irq}, 0);
    endtask

    task automatic t_single_count();
        clear_mem();
        for (int i = 1; i <= 8; i++) push(0, 32'h1000 + i);
        push(1, 32'h2001);
        configure(8'h81, 5'd3, 0, 1, 32'hFFFF_FFFF, 8'd5, 16'd1000);
        wait_irqs(2);
        check("R7 irq0 count", 32'(log_cnt[0]), 4);
        check("R9 irq0 half", 32'(log_half[0]), 0);
        check("R10 irq0 chan", 32'(log_chan[0]), 3);
        check("R5 count word h0", mem_m[0], 4);
        for (int i = 0; i < 4; i++) check("R4 R5 entry h0", mem_m[1+i], 32'h1001 + i);
        check("R9 irq1 half", 32'(log_half[1]), 1);
        check("R5 count word h1", mem_m[5], 4);
        for (int i = 0; i < 4; i++) check("R9 entry h1", mem_m[6+i], 32'h1005 + i);
        check("R2 unselected queue untouched", 32'(tail[1] - head[1]), 1);
        for (int i = 9; i <= 12; i++) push(0, 32'h1000 + i);
        wait_irqs(3);
        check("R11 third irq half", 32'(log_half[2]), 0);
        check("R11 overwrite entry", mem_m[1], 32'h1009);
        check("R11 overwrite last", mem_m[4], 32'h100C);
    endtask

    task automatic t_multi_null();
        int base_n;
        configure(8'h00, 5'd0, 0, 0, 0, 8'd5, 16'd0);
        clear_mem();
        push(0, 32'hA1); push(0, 32'hA2); push(2, 32'hB1); push(5, 32'hC1);
        base_n = irq_n;
        configure(8'h81, 5'd7, 1, 0, 32'h0000_0025, 8'd6, 16'd3);
        cycles(20);
        check("R8 no irq before ticks", 32'(irq_n - base_n), 0);
        ticks(2);
        cycles(5);
        check("R8 no irq before limit", 32'(irq_n - base_n), 0);
        ticks(1);
        wait_irqs(base_n + 1);
        check("R8 irq at limit", 32'(irq_n - base_n), 1);
        check("R3 order 0", mem_m[0], 32'hA1);
        check("R3 order 1", mem_m[1], 32'hB1);
        check("R3 order 2", mem_m[2], 32'hC1);
        check("R3 order 3", mem_m[3], 32'hA2);
        check("R6 terminator", mem_m[4], 0);
        check("R6 no extra write", mem_m[5], 32'hDEAD_BEEF);
        check("R10 count", 32'(log_cnt[base_n]), 4);
        check("R10 chan", 32'(log_chan[base_n]), 7);
        check("R3 unmasked queue untouched", 32'(tail[1] - head[1]), 1);
        // expired pacing with empty half
        ticks(5);
        cycles(10);
        check("R8 no irq while empty", 32'(irq_n - base_n), 1);
        push(2, 32'hB2);
        wait_irqs(base_n + 2);
        check("R8 late entry closes", 32'(log_cnt[base_n+1]), 1);
        check("R9 second half index", 32'(log_half[base_n+1]), 1);
        check("R9 second half entry", mem_m[6], 32'hB2);
        check("R6 second half terminator", mem_m[7], 0);
    endtask

    task automatic t_disable();
        int w, n;
        configure(8'h80, 5'd1, 0, 1, 0, 8'd3, 16'd0);
        clear_mem();
        push(0, 32'hE1);
        w = wr_n; n = irq_n;
        cycles(20);
        check("R1 no pop when off", 32'(tail[0] - head[0]), 1);
        check("R1 no write when off", 32'(wr_n - w), 0);
        check("R1 no irq when off", 32'(irq_n - n), 0);
        configure(8'h81, 5'd1, 0, 1, 0, 8'd3, 16'd0);
        wait_irqs(n + 1);
        check("R1 restart half 0", 32'(log_half[n]), 0);
        check("R8 zero delay count", 32'(log_cnt[n]), 1);
        check("R5 count word", mem_m[0], 1);
        check("R4 entry value", mem_m[1], 32'hE1);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin head[i] = 0; tail[i] = 0; end
        clear_mem();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_single_count();
        t_multi_null();
        t_disable();
        check("R3 pops stay in window", 32'(bad_pop), 0);
        check("R10 single-cycle pulses", 32'(pulse_err), 0);
        check("R9 writes stay in list", 32'(bad_wr), 0);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_cmp++; n_err++;
            $display("FAIL watchdog R1 actual=hung expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end

endmodule